// File: doc/BRIEF.md
# Zero-Page Single-Bit Modify and Branch Unit

This block carries out the single-bit zero-page instructions of an 8-bit processor core. Two opcode groups are handled. The first group reads one zero-page byte, forces one chosen bit to 0 or to 1, and writes the byte back. The second group tests one chosen bit of a zero-page byte and takes a signed relative branch when that bit matches the wanted polarity. The opcode's upper nibble selects both the polarity and the bit number, so the decode needs no lookup table.

A sequencer hands over an already fetched opcode and the current program counter with a one-cycle `start` pulse. The unit then reads its operand bytes and the target byte over a byte-wide synchronous memory port. Read data returns on the cycle after the read strobe, and only one access is in flight at any time. When the instruction finishes, the unit raises `done` for one cycle, together with the next program counter and the number of cycles the instruction costs. The sequencer uses that count for cycle-exact timing.

Top module: `zpb_unit`

## Requirements
- R1: A started opcode with low nibble 0x7 is a bit modify. A started opcode with low nibble 0xF is a bit branch. Any other opcode is refused: it causes no memory access and no `done`.
- R2: Opcode bit 7 gives the polarity: 0 clears the bit or branches when it is 0, and 1 sets the bit or branches when it is 1. Opcode bits 6:4 give the bit number, 0 to 7.
- R3: A bit modify reads the zero-page address from PC+1, reads the byte at 0x00nn, and writes it back to 0x00nn with only the chosen bit changed. It returns PC+2 and a cost of 5.
- R4: A bit branch reads the zero-page address from PC+1 and the displacement from PC+2, and writes nothing. When it is not taken, it returns PC+3 and a cost of 5.
- R5: A taken branch returns PC+3 plus the sign-extended displacement, modulo 65536, and a cost of 6.
- R6: A taken branch whose target high byte differs from the high byte of PC+3 costs 7. This holds for forward and backward crossings and for wraps past 0xFFFF.
- R7: `done` is high for exactly one cycle. It rises 4 cycles after the sampled `start` for a modify and 5 cycles after for a branch. A modify makes 2 reads and 1 write; a branch makes 3 reads. A read and a write never happen in the same cycle.
- R8: A `start` that arrives while an instruction is in flight is ignored.
- R9: While reset is held, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| opcode | input | 8 | Fetched opcode |
| pc_in | input | ADDR_W | Address of the opcode |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | ADDR_W | Program counter after the instruction |
| cycles | output | CYC_W | Cycle cost of the instruction |

## Verification
The bench builds the unit with its defaults: a 16-bit address, 8-bit pages, page penalty on, and cycle costs 5, 5 and 6. With a full 16-bit counter, the bench can place a branch at 0xFFF0 and check the target wrap and the extra cycle for a page crossing in a single case. With the penalty on, both backward and forward crossings can be told apart from branches that stay in the page. The memory model counts reads and writes, so any unexpected write from a branch is seen at the port.

// File: rtl/zpb_pkg.sv
package zpb_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ZS_IDLE,
      ZS_OPND,
      ZS_FETCH,
      ZS_ACT,
      ZS_DISP
   } zpb_state_e;

   typedef struct packed {
      logic       modify;
      logic       branch;
      logic       set_pol;
      logic [2:0] bit_sel;
   } zpb_op_t;

endpackage

// File: rtl/zpb_decode.sv
module zpb_decode
   import zpb_pkg::*;
(
   input  logic [BYTE_W-1:0] opcode,
   output zpb_op_t           info
);

   always_comb begin
      info.modify  = (opcode[3:0] == 4'h7);
      info.branch  = (opcode[3:0] == 4'hF);
      info.set_pol = opcode[7];
      info.bit_sel = opcode[6:4];
   end

endmodule

// File: rtl/zpb_bitop.sv
module zpb_bitop
   import zpb_pkg::*;
(
   input  logic [BYTE_W-1:0] din,
   input  logic [2:0]        bit_sel,
   input  logic              set_pol,
   output logic [BYTE_W-1:0] dout
);

   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign dout[i] = (bit_sel == 3'(i)) ? set_pol : din[i];
   end

endmodule

// File: rtl/zpb_target.sv
module zpb_target
   import zpb_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PAGE_BITS     = 8,
   parameter int CYC_W         = 4,
   parameter int CYC_MODIFY    = 5,
   parameter int CYC_NOT_TAKEN = 5,
   parameter int CYC_TAKEN     = 6,
   parameter bit PAGE_PENALTY  = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              is_branch,
   input  logic              taken,
   input  logic [BYTE_W-1:0] disp,
   output logic [ADDR_W-1:0] next_pc,
   output logic [CYC_W-1:0]  cycles
);

   localparam int EXT_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] jump_pc;
   logic              extra;

   assign seq_pc  = pc + (is_branch ? ADDR_W'(3) : ADDR_W'(2));
   assign jump_pc = seq_pc + {{EXT_W{disp[BYTE_W-1]}}, disp};

   if (PAGE_PENALTY) begin : g_penalty
      assign extra = (seq_pc[ADDR_W-1:PAGE_BITS] != jump_pc[ADDR_W-1:PAGE_BITS]);
   end else begin : g_flat
      assign extra = 1'b0;
   end

   always_comb begin
      next_pc = seq_pc;
      cycles  = CYC_W'(CYC_MODIFY);
      if (is_branch) begin
         if (taken) begin
            next_pc = jump_pc;
            cycles  = CYC_W'(CYC_TAKEN) + CYC_W'(extra);
         end else begin
            cycles  = CYC_W'(CYC_NOT_TAKEN);
         end
      end
   end

endmodule

// File: rtl/zpb_unit.sv
module zpb_unit
   import zpb_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PAGE_BITS     = 8,
   parameter int CYC_W         = 4,
   parameter int CYC_MODIFY    = 5,
   parameter int CYC_NOT_TAKEN = 5,
   parameter int CYC_TAKEN     = 6,
   parameter bit PAGE_PENALTY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [ADDR_W-1:0] pc_in,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] next_pc,
   output logic [CYC_W-1:0]  cycles
);

   localparam int HI_W    = ADDR_W - BYTE_W;
   localparam int MAX_CYC = CYC_TAKEN + (PAGE_PENALTY ? 1 : 0);

   if (ADDR_W <= BYTE_W) begin : g_chk_addr
      $error("ADDR_W must exceed the zero-page width");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_chk_page
      $error("PAGE_BITS out of range");
   end
   if (MAX_CYC >= (1 << CYC_W) || CYC_MODIFY >= (1 << CYC_W)) begin : g_chk_cyc
      $error("CYC_W too narrow for the cycle costs");
   end

   zpb_state_e        state_q;
   zpb_op_t           dec_info, info_q;
   logic [ADDR_W-1:0] pc_q;
   logic [BYTE_W-1:0] za_q, zb_q;
   logic [BYTE_W-1:0] mod_byte;
   logic [ADDR_W-1:0] tgt_pc;
   logic [CYC_W-1:0]  tgt_cyc;
   logic              taken;
   logic              done_q;
   logic [ADDR_W-1:0] npc_q;
   logic [CYC_W-1:0]  cyc_q;

   zpb_decode u_dec (
      .opcode (opcode),
      .info   (dec_info)
   );

   zpb_bitop u_bit (
      .din     (mem_rdata),
      .bit_sel (info_q.bit_sel),
      .set_pol (info_q.set_pol),
      .dout    (mod_byte)
   );

   assign taken = (zb_q[info_q.bit_sel] == info_q.set_pol);

   zpb_target #(
      .ADDR_W        (ADDR_W),
      .PAGE_BITS     (PAGE_BITS),
      .CYC_W         (CYC_W),
      .CYC_MODIFY    (CYC_MODIFY),
      .CYC_NOT_TAKEN (CYC_NOT_TAKEN),
      .CYC_TAKEN     (CYC_TAKEN),
      .PAGE_PENALTY  (PAGE_PENALTY)
   ) u_tgt (
      .pc        (pc_q),
      .is_branch (info_q.branch),
      .taken     (taken),
      .disp      (mem_rdata),
      .next_pc   (tgt_pc),
      .cycles    (tgt_cyc)
   );

   // memory port: one access per cycle, read data lands one cycle later
   always_comb begin
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state_q)
         ZS_OPND: begin
            mem_rd   = 1'b1;
            mem_addr = pc_q + ADDR_W'(1);
         end
         ZS_FETCH: begin
            mem_rd   = 1'b1;
            mem_addr = {{HI_W{1'b0}}, mem_rdata};
         end
         ZS_ACT: begin
            if (info_q.modify) begin
               mem_wr    = 1'b1;
               mem_addr  = {{HI_W{1'b0}}, za_q};
               mem_wdata = mod_byte;
            end else begin
               mem_rd   = 1'b1;
               mem_addr = pc_q + ADDR_W'(2);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ZS_IDLE;
         info_q  <= '0;
         pc_q    <= '0;
         za_q    <= '0;
         zb_q    <= '0;
         done_q  <= 1'b0;
         npc_q   <= '0;
         cyc_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ZS_IDLE: begin
               if (start && (dec_info.modify || dec_info.branch)) begin
                  info_q  <= dec_info;
                  pc_q    <= pc_in;
                  state_q <= ZS_OPND;
               end
            end
            ZS_OPND:  state_q <= ZS_FETCH;
            ZS_FETCH: begin
               za_q    <= mem_rdata;
               state_q <= ZS_ACT;
            end
            ZS_ACT: begin
               zb_q <= mem_rdata;
               if (info_q.modify) begin
                  done_q  <= 1'b1;
                  npc_q   <= tgt_pc;
                  cyc_q   <= tgt_cyc;
                  state_q <= ZS_IDLE;
               end else begin
                  state_q <= ZS_DISP;
               end
            end
            ZS_DISP: begin
               done_q  <= 1'b1;
               npc_q   <= tgt_pc;
               cyc_q   <= tgt_cyc;
               state_q <= ZS_IDLE;
            end
            default: state_q <= ZS_IDLE;
         endcase
      end
   end

   assign done    = done_q;
   assign next_pc = npc_q;
   assign cycles  = cyc_q;

   // R7: never a read and a write together
   p_single_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7: completion is a one-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: write-back stays inside the zero page
   p_wr_zero_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr[ADDR_W-1:BYTE_W] == '0));

   // R3: a write is always preceded by the read of the byte it modifies
   p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));

   // R6: reported cost is one of the legal values
   p_cost_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles == CYC_W'(CYC_MODIFY) || cycles == CYC_W'(CYC_NOT_TAKEN) ||
                cycles == CYC_W'(CYC_TAKEN)  || cycles == CYC_W'(MAX_CYC)));

   // R8: a start while busy does not disturb the captured program counter
   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ZS_IDLE && $past(state_q) != ZS_IDLE) |-> $stable(pc_q));

endmodule

// File: tb/tb_zpb_unit.sv
`timescale 1ns/1ps
module tb_zpb_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [15:0] pc_in = 16'h0000;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        done;
   logic [15:0] next_pc;
   logic [3:0]  cycles;

   int total = 0;
   int bad   = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic both_seen = 1'b0;

   logic [7:0] mem [0:1023];

   always #4 clk = ~clk;

   zpb_unit dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .pc_in     (pc_in),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .done      (done),
      .next_pc   (next_pc),
      .cycles    (cycles)
   );

   // memory model: 1 KiB aliased window, one-cycle read latency
   always @(posedge clk) begin
      if (mem_wr) begin
         mem[mem_addr[9:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) begin
         mem_rdata <= mem[mem_addr[9:0]];
         rd_cnt <= rd_cnt + 1;
      end
      if (mem_rd && mem_wr) both_seen <= 1'b1;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // stimulus: opcode, pc, zp address, zp byte, displacement
   localparam logic [47:0] VECS [0:11] = '{
      {8'h07, 16'h1200, 8'h10, 8'hFF, 8'h00},
      {8'hF7, 16'h1300, 8'h20, 8'h00, 8'h00},
      {8'h57, 16'h1210, 8'h30, 8'hDF, 8'h00},
      {8'h0F, 16'h1280, 8'h40, 8'h01, 8'h10},
      {8'h0F, 16'h1200, 8'h41, 8'hFE, 8'h10},
      {8'h8F, 16'h1210, 8'h42, 8'h01, 8'hF0},
      {8'hFF, 16'h12F0, 8'h43, 8'h80, 8'h20},
      {8'h7F, 16'h1280, 8'h44, 8'h7F, 8'h80},
      {8'hBF, 16'hFFF0, 8'h45, 8'h08, 8'h20},
      {8'h3F, 16'h1300, 8'h46, 8'hF7, 8'hF0},
      {8'hA7, 16'h1220, 8'hFF, 8'h00, 8'h00},
      {8'hCF, 16'h1230, 8'h00, 8'hEF, 8'h05}
   };

   task automatic run_vec(input logic [47:0] v);
      logic [7:0]  op, za, zv, disp, exp_byte;
      logic [15:0] pc, base, tgt, exp_pc;
      int          exp_cyc, exp_lat, lat, rd0, wr0;
      logic        is_mod, bitv, tk;
      op = v[47:40]; pc = v[39:24]; za = v[23:16]; zv = v[15:8]; disp = v[7:0];
      mem[10'(pc + 16'd1)] = za;
      mem[10'(pc + 16'd2)] = disp;
      mem[{2'b00, za}]     = zv;
      is_mod = (op[3:0] == 4'h7);
      bitv   = zv[op[6:4]];
      if (is_mod) begin
         exp_byte = zv;
         exp_byte[op[6:4]] = op[7];
         exp_pc = pc + 16'd2; exp_cyc = 5; exp_lat = 4;
      end else begin
         exp_byte = zv;
         base = pc + 16'd3;
         tgt  = base + {{8{disp[7]}}, disp};
         tk   = (bitv == op[7]);
         exp_lat = 5;
         if (tk) begin
            exp_pc = tgt;
            exp_cyc = (tgt[15:8] != base[15:8]) ? 7 : 6;
         end else begin
            exp_pc = base; exp_cyc = 5;
         end
      end
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      start = 1'b1; opcode = op; pc_in = pc;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk("R7", "latency", lat, exp_lat);
      chk(is_mod ? "R3" : (exp_cyc == 5 ? "R4" : "R5"), "next_pc", next_pc, exp_pc);
      chk(exp_cyc == 7 ? "R6" : (is_mod ? "R3" : "R5"), "cycles", cycles, exp_cyc);
      @(negedge clk);
      chk("R7", "done width", done, 0);
      chk(is_mod ? "R2" : "R4", "zp byte", mem[{2'b00, za}], exp_byte);
      chk("R7", "reads", rd_cnt - rd0, is_mod ? 2 : 3);
      chk(is_mod ? "R3" : "R4", "writes", wr_cnt - wr0, is_mod ? 1 : 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int rd0, wr0, dn;
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9", "done in reset", done, 0);
      chk("R9", "rd in reset", mem_rd, 0);
      chk("R9", "wr in reset", mem_wr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6: table walk
      for (int k = 0; k < 12; k++) run_vec(VECS[k]);

      // R1: out-of-scope opcode is refused
      rd0 = rd_cnt; wr0 = wr_cnt; dn = 0;
      @(negedge clk);
      start = 1'b1; opcode = 8'hEA; pc_in = 16'h1200;
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < 8; j++) begin
         if (done) dn++;
         @(negedge clk);
      end
      chk("R1", "refused done", dn, 0);
      chk("R1", "refused accesses", (rd_cnt - rd0) + (wr_cnt - wr0), 0);

      // R8: start while busy is ignored
      mem[10'h201] = 8'h50; mem[10'h050] = 8'h00;
      mem[10'h301] = 8'h51; mem[10'h051] = 8'h00;
      dn = 0;
      @(negedge clk);
      start = 1'b1; opcode = 8'h87; pc_in = 16'h1200;
      @(negedge clk);
      opcode = 8'hF7; pc_in = 16'h1300;
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < 12; j++) begin
         if (done) begin
            dn++;
            chk("R8", "busy next_pc", next_pc, 16'h1202);
         end
         @(negedge clk);
      end
      chk("R8", "busy done count", dn, 1);
      chk("R8", "first byte", mem[10'h050], 8'h01);
      chk("R8", "second byte", mem[10'h051], 8'h00);
      chk("R7", "no read with write", both_seen, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule